// File: doc/BRIEF.md
# Serial Register Control Port

This block gives a host processor access to a small bank of byte-wide registers over a handful of wires. A parallel address bus picks one register. A single data line carries the byte one bit at a time, least significant bit first, and every bit moves on a falling edge of a host-supplied shift clock. Two active-low strobes set the direction of each transfer. The read strobe turns the data line around toward the host and takes a snapshot of the addressed register. The write strobe commits the bits shifted in so far.

Every host signal is sampled by the system clock through a synchronizer chain, and the block detects all edges inside the system clock domain. The lower register addresses hold writable control bytes, which drive the control outputs. The upper addresses return status inputs and cannot be written. The port responds only while the mode-enable input is high and the active-low select is low. The data line is modelled as an output value plus an output enable.

Top module: `sreg_port`

## Requirements
- R1: After reset every control byte on `ctrl_o` is zero and `sdata_oe` is low.
- R2: With the port enabled and `rd_n_i` high, each falling `sclk_i` edge shifts `sdata_i` into an 8-bit input register. The first bit shifted in ends up as bit 0 after eight shifts. A rising edge of `wr_n_i` then writes that register into the control byte chosen by `addr_i`. Control byte k is `ctrl_o[8k+7:8k]`.
- R3: A falling edge of `rd_n_i` captures the addressed register. Bit 0 is presented on `sdata_o` first. After n further falling `sclk_i` edges, bit n is presented.
- R4: `sdata_oe` is high only while `rd_n_i` is low and the port is enabled, and it drops once `rd_n_i` returns high.
- R5: While `ale_i` is low or `cs_n_i` is high, the port does nothing. Shift clocks, write strobes and read strobes have no effect, and the data line stays undriven.
- R6: Addresses 6 and 7 are read-only. Reads there return `status_i[7:0]` and `status_i[15:8]` respectively, and writes there leave every control byte unchanged.
- R7: A read in progress keeps returning the value captured at the falling read strobe, even if the source changes afterwards.
- R8: If `wr_n_i` rises after fewer than eight shift clocks, the input register is committed as it stands. That value is the older bits moved down, plus the new bits in the upper positions.
- R9: Host inputs pass through two synchronizer flops. The system clock must run at least four times faster than the shift clock and the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Serial mode enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| addr_i | input | 3 | Register address |
| sclk_i | input | 1 | Host shift clock |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| sdata_i | input | 1 | Serial data from host |
| sdata_o | output | 1 | Serial data to host |
| sdata_oe | output | 1 | Output enable for the data line |
| status_i | input | 16 | Status bytes for the read-only addresses |
| ctrl_o | output | 48 | Writable control bytes 0..5 |

## Verification
The hardest situation to reach is a read whose source changes halfway through the byte. To build it, the bench holds a status byte, drops the read strobe, and rewrites `status_i` after the fourth bit. It then checks that the remaining bits still follow the original snapshot. A similar case is the partial write. Here the bench shifts only three bits after a full byte has been loaded, so the committed value mixes stale and fresh bits, and the bench predicts it from its own model of the input register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   // Synchronized host control lines, bundled for the synchronizer chain
   typedef struct packed {
      logic ale;
      logic cs_n;
      logic sclk;
      logic rd_n;
      logic wr_n;
      logic sdata;
   } host_ctl_t;

   localparam int unsigned CTL_W = $bits(host_ctl_t);
   // Idle levels: strobes and shift clock high, enable low
   localparam host_ctl_t CTL_IDLE = '{ale: 1'b0, cs_n: 1'b1, sclk: 1'b1,
                                      rd_n: 1'b1, wr_n: 1'b1, sdata: 1'b0};
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sreg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage[s] <= RST_VAL;
         end else if (s == 0) begin
            stage[s] <= d;
         end else begin
            stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shin_en,
   input  logic              shout_en,
   input  logic              load_en,
   input  logic              din_bit,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] sin_q,
   output logic              dout_bit
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sreg_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sout_q;

   // Input register: new bits enter at the top, LSB-first order
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_q <= '0;
      end else if (shin_en) begin
         sin_q <= {din_bit, sin_q[DATA_W-1:1]};
      end
   end

   // Output register: snapshot on load, then move toward bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sout_q <= '0;
      end else if (load_en) begin
         sout_q <= load_val;
      end else if (shout_en) begin
         sout_q <= {1'b0, sout_q[DATA_W-1:1]};
      end
   end

   assign dout_bit = sout_q[0];
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NUM_RO = 2,
   localparam int unsigned NREGS  = 1 << ADDR_W,
   localparam int unsigned NUM_RW = NREGS - NUM_RO
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_RO*DATA_W-1:0] status_i,
   output logic [DATA_W-1:0]        rdata,
   output logic [NUM_RW*DATA_W-1:0] ctrl_o
);
   if (NUM_RO < 1 || NUM_RO >= NREGS) begin : g_bad_ro
      $error("sreg_bank: NUM_RO must lie between 1 and NREGS-1");
   end

   logic [DATA_W-1:0] rd_arr [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i < NUM_RW) begin : g_rw
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (addr == ADDR_W'(i))) begin
               q <= wdata;
            end
         end
         assign ctrl_o[i*DATA_W +: DATA_W] = q;
         assign rd_arr[i] = q;
      end else begin : g_ro
         assign rd_arr[i] = status_i[(i-NUM_RW)*DATA_W +: DATA_W];
      end
   end

   assign rdata = rd_arr[addr];
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned NUM_RO      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NREGS  = 1 << ADDR_W,
   localparam int unsigned NUM_RW = NREGS - NUM_RO
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ale_i,
   input  logic                     cs_n_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     sclk_i,
   input  logic                     rd_n_i,
   input  logic                     wr_n_i,
   input  logic                     sdata_i,
   output logic                     sdata_o,
   output logic                     sdata_oe,
   input  logic [NUM_RO*DATA_W-1:0] status_i,
   output logic [NUM_RW*DATA_W-1:0] ctrl_o
);
   import sreg_pkg::*;

   localparam int unsigned SYNC_W = CTL_W + ADDR_W;
   localparam logic [SYNC_W-1:0] SYNC_RST = {CTL_IDLE, {ADDR_W{1'b0}}};

   host_ctl_t         ctl_raw, ctl_s, ctl_p;
   logic [ADDR_W-1:0] addr_s;
   logic              active;
   logic              sclk_fall, rd_fall, wr_rise;
   logic [DATA_W-1:0] sin_q, rdata;

   assign ctl_raw = '{ale: ale_i, cs_n: cs_n_i, sclk: sclk_i,
                      rd_n: rd_n_i, wr_n: wr_n_i, sdata: sdata_i};

   sreg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctl_raw, addr_i}),
      .q     ({ctl_s, addr_s})
   );

   // One more sample for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_p <= CTL_IDLE;
      else        ctl_p <= ctl_s;
   end

   assign active    = ctl_s.ale & ~ctl_s.cs_n;
   assign sclk_fall = active & ctl_p.sclk & ~ctl_s.sclk;
   assign rd_fall   = active & ctl_p.rd_n & ~ctl_s.rd_n;
   assign wr_rise   = active & ~ctl_p.wr_n & ctl_s.wr_n;

   sreg_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shin_en  (sclk_fall & ctl_s.rd_n),
      .shout_en (sclk_fall & ~ctl_s.rd_n),
      .load_en  (rd_fall),
      .din_bit  (ctl_s.sdata),
      .load_val (rdata),
      .sin_q    (sin_q),
      .dout_bit (sdata_o)
   );

   sreg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RO(NUM_RO)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_rise),
      .addr     (addr_s),
      .wdata    (sin_q),
      .status_i (status_i),
      .rdata    (rdata),
      .ctrl_o   (ctrl_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sdata_oe <= 1'b0;
      else        sdata_oe <= active & ~ctl_s.rd_n;
   end
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NUM_RW = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     act_s,
   input logic                     sclk_s,
   input logic                     rd_n_s,
   input logic                     wr_n_s,
   input logic [ADDR_W-1:0]        addr_s,
   input logic                     sdata_o,
   input logic                     sdata_oe,
   input logic [NUM_RW*DATA_W-1:0] ctrl_o
);
   // R4
   oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdata_oe |-> $past(!rd_n_s));

   // R5
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_s |=> !sdata_oe);

   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_s && $rose(wr_n_s)) |=> $stable(ctrl_o));

   // R6
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_n_s) && (int'(addr_s) >= NUM_RW)) |=> $stable(ctrl_o));

   // R3
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_s && ($fell(sclk_s) || $fell(rd_n_s))) |=> $stable(sdata_o));
endmodule

bind sreg_port sreg_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RW(NUM_RW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .act_s    (active),
   .sclk_s   (ctl_s.sclk),
   .rd_n_s   (ctl_s.rd_n),
   .wr_n_s   (ctl_s.wr_n),
   .addr_s   (addr_s),
   .sdata_o  (sdata_o),
   .sdata_oe (sdata_oe),
   .ctrl_o   (ctrl_o)
);

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ale_i = 1'b1, cs_n_i = 1'b0, sclk_i = 1'b1;
   logic        rd_n_i = 1'b1, wr_n_i = 1'b1, sdata_i = 1'b0;
   logic [2:0]  addr_i = '0;
   logic        sdata_o, sdata_oe;
   logic [15:0] status_i = 16'hA55A;
   logic [47:0] ctrl_o;

   int n_chk = 0, n_fail = 0;
   logic [7:0] m_sin = '0;          // model of the input register
   logic [7:0] m_ctrl [6];          // model of the control bytes

   always #2 clk = ~clk;

   sreg_port u_dut (
      .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .cs_n_i(cs_n_i), .addr_i(addr_i),
      .sclk_i(sclk_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .sdata_i(sdata_i),
      .sdata_o(sdata_o), .sdata_oe(sdata_oe), .status_i(status_i), .ctrl_o(ctrl_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic port_on();
      return ale_i && !cs_n_i;
   endfunction

   task automatic shift_bit(input logic b);
      sdata_i = b; sclk_i = 1'b1; hold(4);
      sclk_i = 1'b0; hold(6);
      if (port_on() && rd_n_i) m_sin = {b, m_sin[7:1]};
   endtask

   task automatic pulse_wr(input logic [2:0] a);
      addr_i = a; wr_n_i = 1'b0; hold(4);
      wr_n_i = 1'b1; hold(6);
      if (port_on() && a < 3'd6) m_ctrl[a] = m_sin;
   endtask

   task automatic write_byte(input logic [2:0] a, input logic [7:0] v);
      addr_i = a;
      for (int i = 0; i < 8; i++) shift_bit(v[i]);
      pulse_wr(a);
   endtask

   task automatic check_ctrl(input string req);
      for (int k = 0; k < 6; k++) chk(req, 64'(ctrl_o[k*8 +: 8]), 64'(m_ctrl[k]));
   endtask

   task automatic read_byte(input string req, input logic [2:0] a, input logic [7:0] exp);
      addr_i = a; rd_n_i = 1'b0; hold(6);
      chk("R4", 64'(sdata_oe), 64'd1);
      chk(req, 64'(sdata_o), 64'(exp[0]));
      for (int i = 1; i < 8; i++) begin
         sclk_i = 1'b1; hold(4); sclk_i = 1'b0; hold(6);
         chk(req, 64'(sdata_o), 64'(exp[i]));
      end
      rd_n_i = 1'b1; hold(6);
      chk("R4", 64'(sdata_oe), 64'd0);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      for (int k = 0; k < 6; k++) m_ctrl[k] = '0;
      hold(5); rst_n = 1'b1; hold(4);
      // R1 reset state
      chk("R1", 64'(ctrl_o), 64'd0);
      chk("R1", 64'(sdata_oe), 64'd0);

      // R2/R3/R9 sweep over all writable addresses with several patterns
      for (int p = 0; p < 3; p++) begin
         for (int a = 0; a < 6; a++) begin
            v = 8'((a * 37 + 5 + p * 91) ^ (p * 8'h5A));
            write_byte(3'(a), v);
            check_ctrl("R2");
         end
         for (int a = 0; a < 6; a++) read_byte("R3", 3'(a), m_ctrl[a]);
      end
      write_byte(3'd0, 8'hFF); check_ctrl("R2");
      write_byte(3'd0, 8'h00); check_ctrl("R2");

      // R6 read-only addresses
      read_byte("R6", 3'd6, status_i[7:0]);
      read_byte("R6", 3'd7, status_i[15:8]);
      write_byte(3'd6, 8'h3C); check_ctrl("R6");
      write_byte(3'd7, 8'hC3); check_ctrl("R6");

      // R7 snapshot survives a mid-read source change
      status_i = 16'h0096;
      addr_i = 3'd6; rd_n_i = 1'b0; hold(6);
      chk("R7", 64'(sdata_o), 64'd0);
      for (int i = 1; i < 8; i++) begin
         sclk_i = 1'b1; hold(4); sclk_i = 1'b0; hold(6);
         if (i == 4) status_i = 16'h0069;
         chk("R7", 64'(sdata_o), 64'(8'h96 >> i) & 64'd1);
      end
      rd_n_i = 1'b1; hold(6);

      // R8 partial write after a full byte
      write_byte(3'd1, 8'hB4);
      shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
      pulse_wr(3'd2);
      chk("R8", 64'(ctrl_o[2*8 +: 8]), 64'(8'hB4 >> 3 | 8'hA0));
      check_ctrl("R8");

      // R5 port disabled by select, then by mode enable
      cs_n_i = 1'b1; hold(4);
      write_byte(3'd0, 8'h77); check_ctrl("R5");
      rd_n_i = 1'b0; hold(6); chk("R5", 64'(sdata_oe), 64'd0);
      rd_n_i = 1'b1; hold(4);
      cs_n_i = 1'b0; ale_i = 1'b0; hold(4);
      write_byte(3'd3, 8'h11); check_ctrl("R5");
      rd_n_i = 1'b0; hold(6); chk("R5", 64'(sdata_oe), 64'd0);
      rd_n_i = 1'b1; ale_i = 1'b1; hold(6);
      // input register untouched while disabled: a bare strobe commits old bits
      pulse_wr(3'd4);
      chk("R5", 64'(ctrl_o[4*8 +: 8]), 64'(m_sin));
      read_byte("R3", 3'd4, m_ctrl[4]);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule